// File: doc/BRIEF.md
# Dual-Owner Hardware Semaphore Bank

This block is a bank of hardware semaphores that two bus agents share: a host CPU and a coprocessor core. Each semaphore is free or held by exactly one of the two agents. The agents use it to guard shared data without any software handshake.

The host reaches the bank through one 16-bit register port. The upper byte of a write is a per-semaphore enable mask, and the lower byte carries the value to write. A 1 under an enabled mask bit is a lock attempt. A 0 under an enabled mask bit is a release. The coprocessor has its own set-request and clear-request vectors. Each side reads back a vector that shows which semaphores it holds.

A lock attempt succeeds only on a free semaphore. A release has effect only when it comes from the current holder. When both agents try to lock the same free semaphore in the same cycle, the coprocessor wins. Every change takes effect on the clock edge that ends the access, and the read views show the new state in the following cycle.

Top module: `sem_bank`

## Requirements
- R1: After reset, every semaphore is free, and both read views are all zeros.
- R2: Bits 15:8 of the host read data always read as zero.
- R3: A semaphore whose host mask bit (bit i+8) is 0 keeps its state, whatever the data bit. A cycle with host_we_i low changes no semaphore.
- R4: A host write with mask bit i+8 set and data bit i set locks semaphore i for the host if it is free. From the next cycle, host read bit i is 1.
- R5: A host lock attempt on a semaphore that the coprocessor holds fails. The semaphore stays with the coprocessor.
- R6: A host write with mask bit i+8 set and data bit i clear frees semaphore i only if the host holds it. A semaphore held by the coprocessor is not affected.
- R7: A coprocessor set request on bit i takes semaphore i only if it is free. A semaphore held by the host is not affected.
- R8: A coprocessor clear request on bit i frees semaphore i only if the coprocessor holds it.
- R9: If the host and the coprocessor both try to lock the same free semaphore in one cycle, the coprocessor gets it, and the host reads 0 for that bit.
- R10: Host read bit i is 1 exactly when the host holds semaphore i. cop_held_o bit i is 1 exactly when the coprocessor holds it. The two views never both show 1 for the same bit.
- R11: A release frees the semaphore at the edge that ends that cycle. A lock attempt by the other agent in the same cycle fails. The same attempt made in the next cycle succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write data: mask in 15:8, values in 7:0 |
| host_rdata_o | output | 16 | Host read view: owned-by-host bits in 7:0, zeros above |
| cop_set_i | input | 8 | Coprocessor lock requests, one per semaphore |
| cop_clr_i | input | 8 | Coprocessor release requests, one per semaphore |
| cop_held_o | output | 8 | Coprocessor read view: owned-by-coprocessor bits |

## Verification
Directed steps first walk the bank through each ownership transition. These include writes with a zero mask, and writes with the strobe low carrying a full mask, which show that the mask gates each bit. They also include lock attempts on semaphores the other agent holds, which show that arbitration respects ownership, and release attempts by the agent that does not hold the semaphore. Colliding lock attempts on the same free semaphore confirm that the coprocessor wins. A release paired with a lock by the other agent in the same cycle shows that ownership never passes from one agent to the other in a single edge. A long random phase then drives mixed host writes and coprocessor requests. It compares both read views against a behavioural model on every clock, which catches wrong interactions between bits and wrong priority.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE = 2'b00,
    SEM_HOST = 2'b01,
    SEM_COP  = 2'b10
  } sem_own_e;
endpackage

// File: rtl/sem_host_dec.sv
module sem_host_dec #(
  parameter int NUM_SEM = 8,
  localparam int HOST_W = 2 * NUM_SEM
) (
  input  logic              we_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [NUM_SEM-1:0] lock_o,
  output logic [NUM_SEM-1:0] rel_o
);
  logic [NUM_SEM-1:0] mask, val;

  assign mask = wdata_i[HOST_W-1:NUM_SEM];
  assign val  = wdata_i[NUM_SEM-1:0];

  always_comb begin
    lock_o = '0;
    rel_o  = '0;
    if (we_i) begin
      lock_o = mask & val;
      rel_o  = mask & ~val;
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_lock_i,
  input  logic host_rel_i,
  input  logic cop_set_i,
  input  logic cop_clr_i,
  output logic host_own_o,
  output logic cop_own_o
);
  sem_own_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEM_FREE: begin
        if (cop_set_i)        state_d = SEM_COP;  // coprocessor wins collisions
        else if (host_lock_i) state_d = SEM_HOST;
      end
      SEM_HOST: if (host_rel_i) state_d = SEM_FREE;
      SEM_COP:  if (cop_clr_i)  state_d = SEM_FREE;
      default:  state_d = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEM_FREE;
    else         state_q <= state_d;
  end

  assign host_own_o = (state_q == SEM_HOST);
  assign cop_own_o  = (state_q == SEM_COP);

  assert_legal_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11);

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_lock_i && !host_rel_i && !cop_set_i && !cop_clr_i) |=> $stable(state_q));

  assert_cop_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEM_FREE && cop_set_i && host_lock_i) |=> cop_own_o);

  assert_host_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEM_FREE && host_lock_i && !cop_set_i) |=> host_own_o);

  assert_cop_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEM_COP && !cop_clr_i) |=> cop_own_o);

  assert_host_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEM_HOST && !host_rel_i) |=> host_own_o);

  assert_no_handover_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEM_FREE) |=> !($past(host_own_o) && cop_own_o) && !($past(cop_own_o) && host_own_o));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM = 8,
  localparam int HOST_W = 2 * NUM_SEM
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [HOST_W-1:0]  host_wdata_i,
  output logic [HOST_W-1:0]  host_rdata_o,
  input  logic [NUM_SEM-1:0] cop_set_i,
  input  logic [NUM_SEM-1:0] cop_clr_i,
  output logic [NUM_SEM-1:0] cop_held_o
);
  logic [NUM_SEM-1:0] host_lock, host_rel, host_held;

  sem_host_dec #(.NUM_SEM(NUM_SEM)) u_dec (
    .we_i    (host_we_i),
    .wdata_i (host_wdata_i),
    .lock_o  (host_lock),
    .rel_o   (host_rel)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    sem_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .host_lock_i (host_lock[i]),
      .host_rel_i  (host_rel[i]),
      .cop_set_i   (cop_set_i[i]),
      .cop_clr_i   (cop_clr_i[i]),
      .host_own_o  (host_held[i]),
      .cop_own_o   (cop_held_o[i])
    );
  end

  // mask field reads back as zero
  assign host_rdata_o = {{NUM_SEM{1'b0}}, host_held};

  assert_mask_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_o[HOST_W-1:NUM_SEM] == '0);

  assert_views_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdata_o[NUM_SEM-1:0] & cop_held_o) == '0);

  assert_masked_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_we_i && cop_set_i == '0 && cop_clr_i == '0) |=>
      $stable(host_rdata_o) && $stable(cop_held_o));
endmodule

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  cset = '0, cclr = '0, cheld;

  int checks = 0;
  int errors = 0;
  int own [N];  // 0 free, 1 host, 2 coprocessor

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank u_sem_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(we), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .cop_set_i(cset), .cop_clr_i(cclr), .cop_held_o(cheld)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_step();
    for (int i = 0; i < N; i++) begin
      if (own[i] == 0) begin
        if (cset[i]) own[i] = 2;
        else if (we && wdata[i+8] && wdata[i]) own[i] = 1;
      end else if (own[i] == 1) begin
        if (we && wdata[i+8] && !wdata[i]) own[i] = 0;
      end else begin
        if (cclr[i]) own[i] = 0;
      end
    end
  endfunction

  function automatic logic [7:0] model_view(input int who);
    logic [7:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (own[i] == who);
    return v;
  endfunction

  // drive at negedge, clock once, compare at the following negedge
  task automatic cyc(input logic w, input logic [15:0] d, input logic [7:0] s, input logic [7:0] c);
    we = w; wdata = d; cset = s; cclr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 1'b0; wdata = '0; cset = '0; cclr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) own[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 host view", rdata, 16'h0000);
    check("R1 cop view", {8'h0, cheld}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(1, 16'h00FF, 0, 0);        check("R3 zero mask", rdata, 16'h0000);
    cyc(0, 16'hFFFF, 0, 0);        check("R3 strobe low", rdata, 16'h0000);
    cyc(1, 16'h0303, 0, 0);        check("R4 host lock", rdata, 16'h0003);
    check("R2 mask reads zero", {8'h0, rdata[15:8]}, 16'h0000);
    cyc(0, 0, 8'h06, 0);           check("R7 cop set", {8'h0, cheld}, 16'h0004);
    check("R7 host kept", rdata, 16'h0003);
    cyc(1, 16'h0404, 0, 0);        check("R5 host lock on cop", rdata, 16'h0003);
    check("R5 cop kept", {8'h0, cheld}, 16'h0004);
    cyc(1, 16'h0400, 0, 0);        check("R6 host release of cop", {8'h0, cheld}, 16'h0004);
    cyc(0, 0, 0, 8'h01);           check("R8 cop clear of host", rdata, 16'h0003);
    cyc(1, 16'h0100, 0, 0);        check("R6 host release", rdata, 16'h0002);
    cyc(1, 16'h0808, 8'h08, 0);    check("R9 cop wins", {8'h0, cheld}, 16'h000C);
    check("R9 host loses", rdata, 16'h0002);
    cyc(1, 16'h0200, 8'h02, 0);    check("R11 same cycle cop", {8'h0, cheld}, 16'h000C);
    check("R11 same cycle host", rdata, 16'h0000);
    cyc(0, 0, 8'h02, 0);           check("R11 next cycle", {8'h0, cheld}, 16'h000E);
    cyc(0, 0, 0, 8'h04);           check("R8 cop clear", {8'h0, cheld}, 16'h000A);

    for (int k = 0; k < 400; k++) begin
      cyc(1'($urandom), 16'($urandom), 8'($urandom) & 8'($urandom),
          8'($urandom) & 8'($urandom));
      check("R10 host view", rdata, {8'h0, model_view(1)});
      check("R10 cop view", {8'h0, cheld}, {8'h0, model_view(2)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule